// File: doc/BRIEF.md
# Stuck-Cell Locating Test Sequencer

This block is a built-in test controller for a programmed NAND-style compute array. After a start pulse it walks the bitlines one after another and finds cells that have drifted into the low-resistance state without having been programmed there. For each bitline it first runs a single screening step. A bitline that passes costs one cycle and is left alone. A bitline that fails is then probed cell by cell, one cycle per cell. The probe is exhaustive rather than a binary search, because a single bitline can carry several stuck cells.

The results form a per-cell fault map, a per-bitline flag taken from the screening result, and a per-wordline flag that is the OR of the cell flags on that row. A masking scheduler consumes these flags. The array itself is a behavioural model inside the block. Its programmed pattern and its injected stuck cells arrive as input vectors. Cell (row r, bitline c) sits at bit index c*ROWS + r of every map vector.

Top module: `cellfault_locator`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are 0 and the cell map, bitline flags and wordline flags are all zero until the first start.
- R2: A start sampled while neither busy nor running begins a test: busy is 1 from the next cycle with done 0. A start sampled while busy has no effect on the run, its length or its results.
- R3: Bitlines are screened one at a time in ascending order. The screening step drives 1 on every wordline whose cell on that bitline is programmed low-resistance and 0 on all other wordlines. A sensed 1 sets that bitline's flag.
- R4: A bitline whose screen senses 0 is never probed and costs exactly one cycle.
- R5: A failed bitline is probed on every row in ascending order, one cycle per row. Each probe drives 0 on the row under test and 1 on all other rows, with the sense reference switched low. A sensed 0 on a cell that is not programmed low-resistance sets that cell's flag. Every stuck cell on the bitline is found, not just the first.
- R6: The cell map holds 1 exactly at the cells that are stuck low-resistance but not programmed so, at index c*ROWS + r.
- R7: Wordline flag r is the OR of the cell-map bits of row r over all bitlines.
- R8: With F failed bitlines, busy stays high for exactly COLS + ROWS*F cycles. Done rises in the cycle after the last step, together with busy falling. All results then hold until the next start.
- R9: A new start clears the cell map and both flag vectors before the first step of the new run.
- R10: A stuck cell on a position that is already programmed low-resistance is not reported, and its bitline passes screening.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run when idle or finished |
| prog_map | input | ROWS*COLS | Programmed low-resistance cells, bit c*ROWS+r |
| stuck_map | input | ROWS*COLS | Injected stuck low-resistance cells of the array model |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished, results valid |
| cell_map | output | ROWS*COLS | Recovered per-cell fault flags |
| bl_flag | output | COLS | Per-bitline fault flags from screening |
| wl_flag | output | ROWS | Per-wordline fault flags |

## Verification
The bench builds the block with 6 wordlines and 5 bitlines. Neither counter then wraps at a power of two, so the last-row and last-bitline decisions have to be right in both counters. With 30 cells, random fault maps often put two or more stuck cells on one bitline and often hit both edge cells. This exercises the multi-fault probing and the exact busy-length formula over many different failed-bitline counts.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SCREEN = 2'd1,
      PH_PROBE  = 2'd2,
      PH_DONE   = 2'd3
   } phase_t;

endpackage

// File: rtl/cfl_array_model.sv
// Behavioural crossbar: a bitline senses high when some effectively
// low-resistance cell on it sees a 0 input; ref_lo flips the sense rail.
module cfl_array_model #(
   parameter int ROWS = 8,
   parameter int COLS = 6
) (
   input  logic [ROWS*COLS-1:0] prog_map,
   input  logic [ROWS*COLS-1:0] stuck_map,
   input  logic [ROWS-1:0]      wl,
   input  logic                 ref_lo,
   output logic [COLS-1:0]      sense
);

   localparam int NCELL = ROWS * COLS;

   logic [NCELL-1:0] eff_lrs;
   assign eff_lrs = prog_map | stuck_map;

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [ROWS-1:0] pull;
      assign pull     = eff_lrs[c*ROWS +: ROWS] & ~wl;
      assign sense[c] = ref_lo ^ (|pull);
   end

endmodule

// File: rtl/cfl_pattern_gen.sv
module cfl_pattern_gen
   import cfl_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 6,
   localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  phase_t               phase,
   input  logic [CW-1:0]        col,
   input  logic [RW-1:0]        row,
   input  logic [ROWS*COLS-1:0] prog_map,
   output logic [ROWS-1:0]      wl,
   output logic                 ref_lo
);

   logic [ROWS-1:0] prog_col [COLS];

   for (genvar c = 0; c < COLS; c++) begin : g_slice
      assign prog_col[c] = prog_map[c*ROWS +: ROWS];
   end

   always_comb begin
      wl     = '0;
      ref_lo = 1'b0;
      case (phase)
         PH_SCREEN: begin
            if (int'(col) < COLS) wl = prog_col[col];
         end
         PH_PROBE: begin
            wl     = ~(ROWS'(1) << row);
            ref_lo = 1'b1;
         end
         default: begin
            wl     = '0;
            ref_lo = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/cfl_seq_fsm.sv
module cfl_seq_fsm
   import cfl_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 6,
   localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int NCELL = ROWS * COLS,
   localparam int IW    = (NCELL > 1) ? $clog2(NCELL) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COLS-1:0]  sense,
   input  logic [NCELL-1:0] prog_map,
   output phase_t           phase,
   output logic [CW-1:0]    col,
   output logic [RW-1:0]    row,
   output logic [NCELL-1:0] cell_map,
   output logic [COLS-1:0]  bl_flag,
   output logic             busy,
   output logic             done
);

   logic [IW-1:0] cell_idx;
   logic          last_col;
   logic          last_row;
   logic          col_sense;

   assign cell_idx  = IW'(col) * IW'(ROWS) + IW'(row);
   assign last_col  = (col == CW'(COLS - 1));
   assign last_row  = (row == RW'(ROWS - 1));
   assign col_sense = sense[col];
   assign busy      = (phase == PH_SCREEN) || (phase == PH_PROBE);
   assign done      = (phase == PH_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         col      <= '0;
         row      <= '0;
         cell_map <= '0;
         bl_flag  <= '0;
      end else begin
         case (phase)
            PH_IDLE, PH_DONE: begin
               if (start) begin
                  phase    <= PH_SCREEN;
                  col      <= '0;
                  row      <= '0;
                  cell_map <= '0;
                  bl_flag  <= '0;
               end
            end
            PH_SCREEN: begin
               if (col_sense) begin
                  bl_flag[col] <= 1'b1;
                  row          <= '0;
                  phase        <= PH_PROBE;
               end else if (last_col) begin
                  phase <= PH_DONE;
               end else begin
                  col <= col + 1'b1;
               end
            end
            PH_PROBE: begin
               if (!col_sense && !prog_map[cell_idx])
                  cell_map[cell_idx] <= 1'b1;
               if (last_row) begin
                  row <= '0;
                  if (last_col) begin
                     phase <= PH_DONE;
                  end else begin
                     col   <= col + 1'b1;
                     phase <= PH_SCREEN;
                  end
               end else begin
                  row <= row + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R5: probing only ever runs on a bitline whose screen failed
   a_r5_probe_on_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PROBE) |-> bl_flag[col]);

   // R4: a passing screen never leads into a probe
   a_r4_good_col_skips: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SCREEN && !col_sense) |=> (phase != PH_PROBE));

   // R2: an accepted start opens the run on bitline 0
   a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (phase == PH_SCREEN && col == '0 && cell_map == '0));

   // R8: finished results hold until a new start
   a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> ($stable(cell_map) && $stable(bl_flag) && done));

endmodule

// File: rtl/cfl_flag_reduce.sv
module cfl_flag_reduce #(
   parameter int ROWS = 8,
   parameter int COLS = 6
) (
   input  logic [ROWS*COLS-1:0] cell_map,
   output logic [ROWS-1:0]      wl_flag
);

   logic [COLS-1:0] row_bits [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_bit
         assign row_bits[r][c] = cell_map[c*ROWS + r];
      end
      assign wl_flag[r] = |row_bits[r];
   end

endmodule

// File: rtl/cellfault_locator.sv
module cellfault_locator
   import cfl_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 6,
   localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int NCELL = ROWS * COLS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NCELL-1:0] prog_map,
   input  logic [NCELL-1:0] stuck_map,
   output logic             busy,
   output logic             done,
   output logic [NCELL-1:0] cell_map,
   output logic [COLS-1:0]  bl_flag,
   output logic [ROWS-1:0]  wl_flag
);

   if (ROWS < 2) begin : g_bad_rows
      $error("cellfault_locator: ROWS must be at least 2");
   end
   if (COLS < 1) begin : g_bad_cols
      $error("cellfault_locator: COLS must be at least 1");
   end

   phase_t          phase;
   logic [CW-1:0]   col;
   logic [RW-1:0]   row;
   logic [ROWS-1:0] wl;
   logic            ref_lo;
   logic [COLS-1:0] sense;

   cfl_seq_fsm #(.ROWS(ROWS), .COLS(COLS)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .sense    (sense),
      .prog_map (prog_map),
      .phase    (phase),
      .col      (col),
      .row      (row),
      .cell_map (cell_map),
      .bl_flag  (bl_flag),
      .busy     (busy),
      .done     (done)
   );

   cfl_pattern_gen #(.ROWS(ROWS), .COLS(COLS)) u_pat (
      .phase    (phase),
      .col      (col),
      .row      (row),
      .prog_map (prog_map),
      .wl       (wl),
      .ref_lo   (ref_lo)
   );

   cfl_array_model #(.ROWS(ROWS), .COLS(COLS)) u_array (
      .prog_map  (prog_map),
      .stuck_map (stuck_map),
      .wl        (wl),
      .ref_lo    (ref_lo),
      .sense     (sense)
   );

   cfl_flag_reduce #(.ROWS(ROWS), .COLS(COLS)) u_reduce (
      .cell_map (cell_map),
      .wl_flag  (wl_flag)
   );

   // R3: screening reads the normal sense rail
   a_r3_screen_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SCREEN) |-> !ref_lo);

   // R5: a probe drives exactly one wordline low on the complement rail
   a_r5_probe_one_low: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PROBE) |-> (ref_lo && $countones(wl) == ROWS - 1));

   // R6: a programmed cell is never reported while a run is in progress
   a_r6_no_programmed_flag: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((cell_map & prog_map) == '0));

   // R8: busy and done never overlap
   a_r8_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

endmodule

// File: tb/test_cellfault_locator.sv
module test_cellfault_locator;

   localparam int NR = 6;
   localparam int NC = 5;
   localparam int NB = NR * NC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NB-1:0] prog_map = '0;
   logic [NB-1:0] stuck_map = '0;
   logic          busy;
   logic          done;
   logic [NB-1:0] cell_map;
   logic [NC-1:0] bl_flag;
   logic [NR-1:0] wl_flag;

   always #2 clk = ~clk;

   cellfault_locator #(.ROWS(NR), .COLS(NC)) i_cellfault_locator (
      .clk(clk), .rst_n(rst_n), .start(start),
      .prog_map(prog_map), .stuck_map(stuck_map),
      .busy(busy), .done(done), .cell_map(cell_map),
      .bl_flag(bl_flag), .wl_flag(wl_flag)
   );

   typedef struct {
      logic [NB-1:0] cells;
      logic [NC-1:0] bl;
      logic [NR-1:0] wl;
      int            cycles;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fails = 0;
   bit   finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic exp_t predict(input logic [NB-1:0] p, input logic [NB-1:0] s);
      exp_t e;
      e.cells  = s & ~p;
      e.bl     = '0;
      e.wl     = '0;
      e.cycles = NC;
      for (int c = 0; c < NC; c++)
         for (int r = 0; r < NR; r++)
            if (e.cells[c*NR + r]) begin
               e.bl[c] = 1'b1;
               e.wl[r] = 1'b1;
            end
      for (int c = 0; c < NC; c++)
         if (e.bl[c]) e.cycles += NR;
      return e;
   endfunction

   // driver: pushes the prediction, launches the run, checks clear and hold
   task automatic run(input logic [NB-1:0] p, input logic [NB-1:0] s, input bit poke);
      exp_t e;
      e = predict(p, s);
      @(negedge clk);
      prog_map  = p;
      stuck_map = s;
      exp_q.push_back(e);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1 && done === 1'b0, "R2", "busy/done after start",
          longint'({busy, done}), 64'h2);
      chk(cell_map === '0 && bl_flag === '0, "R9", "results cleared by start",
          longint'(cell_map), 0);
      if (poke) begin
         start = 1'b1;   // R2: ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      while (done !== 1'b1) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(cell_map === e.cells && bl_flag === e.bl && done === 1'b1, "R8",
          "results held after done", longint'(cell_map), longint'(e.cells));
   endtask

   // monitor: counts busy cycles and compares at each rising done
   initial begin
      int   cnt;
      logic dq;
      exp_t e;
      cnt = 0;
      dq  = 1'b0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            cnt = 0;
            dq  = 1'b0;
         end else begin
            if (busy === 1'b1) cnt++;
            if (done === 1'b1 && dq !== 1'b1) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R8", "done without a launched run", 1, 0);
               end else begin
                  e = exp_q.pop_front();
                  chk(cell_map === e.cells, "R5/R6", "cell map",
                      longint'(cell_map), longint'(e.cells));
                  chk(bl_flag === e.bl, "R3", "bitline flags",
                      longint'(bl_flag), longint'(e.bl));
                  chk(wl_flag === e.wl, "R7", "wordline flags",
                      longint'(wl_flag), longint'(e.wl));
                  // R4 and R8: run length COLS + ROWS*F
                  chk(cnt == e.cycles, "R8", "busy cycle count",
                      longint'(cnt), longint'(e.cycles));
               end
               cnt = 0;
            end
            dq = done;
         end
      end
   end

   function automatic logic [NB-1:0] rand_map(input int odds);
      logic [NB-1:0] m;
      for (int i = 0; i < NB; i++) m[i] = ($urandom_range(odds - 1) == 0);
      return m;
   endfunction

   initial begin
      logic [NB-1:0] p;
      logic [NB-1:0] s;
      void'($urandom(32'd1913));
      repeat (4) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset",
          longint'({busy, done}), 0);
      chk(cell_map === '0 && bl_flag === '0 && wl_flag === '0, "R1",
          "maps in reset", longint'(cell_map), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && cell_map === '0, "R1",
          "idle after reset", longint'({busy, done}), 0);

      // R3/R4: clean array, every bitline passes
      run(rand_map(4), '0, 1'b0);

      // R5/R6: first cell only
      p = rand_map(4); p[0] = 1'b0;
      s = '0; s[0] = 1'b1;
      run(p, s, 1'b0);

      // R5/R6: last cell only
      p = rand_map(4); p[NB-1] = 1'b0;
      s = '0; s[NB-1] = 1'b1;
      run(p, s, 1'b0);

      // R5: several stuck cells on one bitline, all must be found
      p = rand_map(3); p[2*NR +: NR] = '0;
      s = '0; s[2*NR +: NR] = {NR{1'b1}};
      run(p, s, 1'b0);

      // R10: stuck only on programmed positions
      p = rand_map(2); p[0] = 1'b1;
      s = p;
      run(p, s, 1'b0);
      chk(bl_flag === '0 && cell_map === '0, "R10",
          "stuck on programmed cell not reported", longint'(bl_flag), 0);

      // R2: start pulsed while busy has no effect
      p = rand_map(4);
      s = rand_map(3);
      s[0] = 1'b1; p[0] = 1'b0;
      run(p, s, 1'b1);

      // random fault maps
      for (int k = 0; k < 25; k++) begin
         run(rand_map(4), rand_map(7), (k % 5) == 0);
      end

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R8", "all runs completed",
          longint'(exp_q.size()), 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL R8 watchdog expired: actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

endmodule